// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell of a registered programmable logic device. It receives the sum term produced by an OR gate in the product-term array. It holds a single D flip-flop. Two configuration bits choose what the cell does with that sum. The first bit chooses whether the flip-flop is bypassed, which gives a combinational path, or used, which gives a registered path. The second bit chooses whether the pin is active high or active low. The same first bit also chooses what goes back into the array: the flip-flop output or the OR-gate output.

The pin is tristate and is modelled as a data output plus an enable. The enable comes from a product term. While the driver is off, the pin acts as an input, and its outside value is passed to the array instead. The clock, the asynchronous reset and the synchronous preset are shared by all cells of a device. The reset is asynchronous when asserted and is released through a local synchronizer.

Configuration bits follow fuse semantics. A programmed bit pulls its select line to 0. An erased bit leaves the select line at 1. The decoded select lines S1:S0 index a four-input multiplexer, which is followed by an inverting buffer. The multiplexer inputs are Q (index 0), not-Q (index 1), the sum (index 2) and the inverted sum (index 3). For example, select 10 picks index 2.

Top module: `omc_cell`

## Requirements
- R1: Each `cfg_pgm` bit is 1 when programmed, and a programmed bit sets its select line to 0. With `cfg_pgm` = 00 (both bits erased) the select is S1:S0 = 11, the combinational active-high mode. With `cfg_pgm` = 11 the select is 00, the registered active-low mode.
- R2: With S1:S0 = 11 (`cfg_pgm` = 00), `pin_out` equals `sum_in` in the same cycle, with no clock edge needed.
- R3: With S1:S0 = 10 (`cfg_pgm` = 01), `pin_out` equals the inverse of `sum_in` in the same cycle.
- R4: With S1:S0 = 01 (`cfg_pgm` = 10), `pin_out` equals the flip-flop Q. Q takes `sum_in` at each rising clock edge, and `pin_out` does not change between edges.
- R5: With S1:S0 = 00 (`cfg_pgm` = 11), `pin_out` equals the inverse of the flip-flop Q.
- R6: `fb_out` equals `sum_in` when S1 = 1. It equals the true, non-inverted flip-flop Q when S1 = 0, whatever S0 is.
- R7: When `preset` is high at a rising edge while the cell is out of reset, Q becomes 1 whatever `sum_in` is.
- R8: When `arst_n` is low, Q is cleared at once, without waiting for a clock edge. After `arst_n` rises, Q stays 0 through the next two rising edges and first captures data on the third edge.
- R9: While reset is active, Q stays 0 even when `preset` is high.
- R10: `pin_oe` follows `oe_term`. When `oe_term` is 0, `pin_fb` equals `pin_in`. When `oe_term` is 1, `pin_fb` equals `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; the flip-flop updates on the rising edge |
| arst_n | input | 1 | Shared reset, active low; asserts asynchronously and is released synchronously |
| preset | input | 1 | Shared synchronous preset, active high |
| cfg_pgm | input | 2 | Configuration fuses, 1 = programmed; bit 1 controls S1 (bypass), bit 0 controls S0 (polarity) |
| sum_in | input | 1 | Sum term from the OR gate of the product-term array |
| oe_term | input | 1 | Product term that enables the pin driver |
| pin_in | input | 1 | Value sensed on the pin from outside |
| pin_out | output | 1 | Data driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the AND array: Q or the sum, chosen by S1 |
| pin_fb | output | 1 | Pin value returned to the AND array |

## Verification
The hardest state to reach from the ports is the flip-flop's reset release, where reset and preset are both active. To observe the flip-flop there, the registered active-high mode must be selected, because only that mode exposes Q directly on `pin_out`. The stimulus holds `preset` and `sum_in` high while `arst_n` is low, then releases reset on a falling edge. It then checks that the pin stays 0 through two further rising edges and rises on the third. The asynchronous clear is also reached mid-cycle: Q is first loaded with 1, then `arst_n` is pulled low between edges, and the pin is sampled before the next edge arrives.

// File: rtl/omc_pkg.sv
package omc_pkg;

  // Decoded select lines {S1,S0}
  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } omc_mode_e;

  localparam int MUX_WAYS = 4;

  // A programmed fuse grounds its select line; an erased one floats high.
  function automatic omc_mode_e fuse_decode(input logic [1:0] pgm);
    return omc_mode_e'(~pgm);
  endfunction

endpackage

// File: rtl/omc_rst_sync.sv
module omc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

  AST_SYNC_HOLDS_LOW: assert property (@(posedge clk) !arst_n |-> !rst_n_sync) // R8
    else $error("synchronized reset high while reset asserted");

endmodule

// File: rtl/omc_dff.sv
module omc_dff (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic d,
  output logic q
);

  logic q_nxt;
  logic ce;

  always_comb begin
    ce    = 1'b1;
    q_nxt = preset ? 1'b1 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (ce) q <= q_nxt;
  end

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && preset) |=> q) // R7
    else $error("preset did not set the flop");

  AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && !preset) |=> (q == $past(d))) // R4
    else $error("flop did not capture its data input");

  AST_RESET_WINS: assert property (@(posedge clk) (!rst_n && preset) |-> !q) // R9
    else $error("flop set while reset active");

endmodule

// File: rtl/omc_outsel.sv
module omc_outsel
  import omc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  omc_mode_e sel,
  input  logic      q,
  input  logic      sum,
  input  logic      oe_term,
  input  logic      pin_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      fb,
  output logic      pin_fb
);

  logic [MUX_WAYS-1:0] way;
  logic                mux_y;

  // Four data inputs: Q, Q', OR, OR'; polarity pairs built per source
  for (genvar g = 0; g < MUX_WAYS; g++) begin : g_way
    if (g < 2) begin : g_reg
      assign way[g] = (g % 2 == 1) ? ~q : q;
    end else begin : g_comb
      assign way[g] = (g % 2 == 1) ? ~sum : sum;
    end
  end

  always_comb begin
    mux_y   = way[sel];
    pin_out = ~mux_y;                 // inverting output buffer
    pin_oe  = oe_term;
    fb      = sel[1] ? sum : q;
    pin_fb  = oe_term ? pin_out : pin_in;
  end

  AST_HIZ_READS_PIN: assert property (@(posedge clk) disable iff (!rst_n) !oe_term |-> (pin_fb == pin_in)) // R10
    else $error("pin feedback not from pin while driver off");

  AST_COMB_HIGH_PATH: assert property (@(posedge clk) disable iff (!rst_n) (sel == MODE_COMB_HIGH) |-> (pin_out == sum)) // R2
    else $error("combinational active-high path wrong");

  AST_REG_LOW_INVERTS: assert property (@(posedge clk) disable iff (!rst_n) (sel == MODE_REG_LOW) |-> (pin_out != fb)) // R5
    else $error("registered active-low pin not inverse of flop");

endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       preset,
  input  logic [1:0] cfg_pgm,
  input  logic       sum_in,
  input  logic       oe_term,
  input  logic       pin_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       fb_out,
  output logic       pin_fb
);

  logic      rst_n_sync;
  logic      flop_q;
  omc_mode_e mode;

  always_comb mode = fuse_decode(cfg_pgm);

  omc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_sync)
  );

  omc_dff u_dff (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .preset (preset),
    .d      (sum_in),
    .q      (flop_q)
  );

  omc_outsel u_sel (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .sel     (mode),
    .q       (flop_q),
    .sum     (sum_in),
    .oe_term (oe_term),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb_out),
    .pin_fb  (pin_fb)
  );

  AST_FB_TRACKS_FLOP: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (rst_n_sync && !preset && cfg_pgm[1] && $stable(cfg_pgm)) |=> (!cfg_pgm[1] || fb_out == $past(sum_in))) // R6
    else $error("feedback not flop output in registered mode");

  AST_ERASED_IS_COMB: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (cfg_pgm == 2'b00) |-> (pin_out == sum_in && fb_out == sum_in)) // R1
    else $error("erased fuses did not give combinational active-high");

endmodule

// File: tb/sim_omc_cell.sv
module sim_omc_cell;

  logic clk = 1'b0;
  logic arst_n, preset, sum_in, oe_term, pin_in;
  logic [1:0] cfg_pgm;
  logic pin_out, pin_oe, fb_out, pin_fb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  omc_cell u0 (
    .clk(clk), .arst_n(arst_n), .preset(preset), .cfg_pgm(cfg_pgm),
    .sum_in(sum_in), .oe_term(oe_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .pin_fb(pin_fb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk); #2;
  endtask

  task automatic release_reset();
    @(negedge clk) arst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic t_reset_release();
    // Registered active-high: pin shows Q
    chk("R8 held in reset", pin_out, 1'b0);
    @(negedge clk) arst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2 chk("R8 still clear after two edges", pin_out, 1'b0);
    edge_then_sample();
    chk("R8 captures on third edge", pin_out, 1'b1);
  endtask

  task automatic t_erased();
    @(negedge clk) cfg_pgm = 2'b00; sum_in = 1'b0;
    #1 chk("R1 erased fuses follow sum", pin_out, 1'b0);
    sum_in = 1'b1;
    #1 chk("R1 erased fuses follow sum", pin_out, 1'b1);
    @(negedge clk) cfg_pgm = 2'b11; sum_in = 1'b0;
    edge_then_sample();
    chk("R1 all programmed gives registered low", pin_out, 1'b1);
    @(negedge clk) sum_in = 1'b1;
    #1 chk("R1 no change between edges", pin_out, 1'b1);
  endtask

  task automatic t_comb();
    for (int v = 0; v < 2; v++) begin
      @(negedge clk) cfg_pgm = 2'b00; sum_in = v[0];
      #1 chk("R2 comb high pin", pin_out, v[0]);
      chk("R6 comb feedback", fb_out, v[0]);
      cfg_pgm = 2'b01;
      #1 chk("R3 comb low pin", pin_out, ~v[0]);
      chk("R6 comb feedback under low", fb_out, v[0]);
    end
  endtask

  task automatic t_reg_high();
    @(negedge clk) cfg_pgm = 2'b10; sum_in = 1'b0;
    edge_then_sample();
    chk("R4 reg high after 0", pin_out, 1'b0);
    @(negedge clk) sum_in = 1'b1;
    #1 chk("R4 holds until edge", pin_out, 1'b0);
    edge_then_sample();
    chk("R4 reg high after 1", pin_out, 1'b1);
    @(negedge clk) sum_in = 1'b0;
    #1 chk("R6 feedback is flop not sum", fb_out, 1'b1);
  endtask

  task automatic t_reg_low();
    @(negedge clk) cfg_pgm = 2'b11; sum_in = 1'b1;
    edge_then_sample();
    chk("R5 reg low after 1", pin_out, 1'b0);
    chk("R6 true Q feedback under low", fb_out, 1'b1);
    @(negedge clk) sum_in = 1'b0;
    edge_then_sample();
    chk("R5 reg low after 0", pin_out, 1'b1);
    chk("R6 true Q feedback under low", fb_out, 1'b0);
  endtask

  task automatic t_preset();
    @(negedge clk) cfg_pgm = 2'b10; sum_in = 1'b0; preset = 1'b1;
    edge_then_sample();
    chk("R7 preset sets Q", pin_out, 1'b1);
    @(negedge clk) preset = 1'b0;
    edge_then_sample();
    chk("R7 preset released", pin_out, 1'b0);
  endtask

  task automatic t_priority();
    @(negedge clk) cfg_pgm = 2'b10; sum_in = 1'b1; preset = 1'b1; arst_n = 1'b0;
    edge_then_sample();
    chk("R9 reset beats preset", pin_out, 1'b0);
    edge_then_sample();
    chk("R9 reset beats preset again", pin_out, 1'b0);
    release_reset();
    chk("R9 still clear during release", pin_out, 1'b0);
    edge_then_sample();
    chk("R7 preset after release", pin_out, 1'b1);
    @(negedge clk) preset = 1'b0;
  endtask

  task automatic t_async();
    @(negedge clk) cfg_pgm = 2'b10; sum_in = 1'b1;
    edge_then_sample();
    chk("R4 loaded before async", pin_out, 1'b1);
    #1 arst_n = 1'b0;
    #1 chk("R8 async clear without edge", pin_out, 1'b0);
    release_reset();
  endtask

  task automatic t_pin();
    @(negedge clk) cfg_pgm = 2'b00; sum_in = 1'b1; oe_term = 1'b0;
    for (int v = 0; v < 2; v++) begin
      pin_in = v[0];
      #1 chk("R10 driver off", pin_oe, 1'b0);
      chk("R10 pin read when off", pin_fb, v[0]);
    end
    oe_term = 1'b1; pin_in = 1'b0;
    #1 chk("R10 driver on", pin_oe, 1'b1);
    chk("R10 driven value read back", pin_fb, 1'b1);
  endtask

  initial begin
    arst_n = 1'b0; preset = 1'b0; cfg_pgm = 2'b10;
    sum_in = 1'b1; oe_term = 1'b1; pin_in = 1'b0;
    #12;
    t_reset_release();
    t_erased();
    t_comb();
    t_reg_high();
    t_reg_low();
    t_preset();
    t_priority();
    t_async();
    t_pin();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule